// File: doc/BRIEF.md
# Two-Wire Debug Byte Shifter

This block is the host end of a slow, bit-serial debug link to a small target controller. It drives one clock wire and shares a single data wire with the target. It moves whole bytes in either direction and frames complete debug-instruction commands on its own. Requests come in over a valid/ready pair. Completion is a one-cycle pulse that carries the byte read back from the target.

A request is one of three kinds. A send shifts out one byte. A receive clocks in one byte. An instruction sends a header byte that carries the operand count, then that many operand bytes, and then reads the target's one-byte reply without being asked again. The data wire is enabled as an output only while host bytes go out, so the target can drive it during reads. A divider parameter sets how many system clocks each half of a link bit lasts.

Top module: `dbg_link_shifter`

## Requirements
- R1: Out of reset and whenever idle, `linkClk` is 1, `linkDataOe` is 0, `busy` is 0 and `reqReady` is 1.
- R2: A send (`reqKind` = 2'b00) transmits `reqOperands[7:0]` as 8 bits, most significant bit first. Each bit is put on `linkDataOut` at the start of a clock-high phase and held unchanged through the following clock-low phase.
- R3: `linkDataOe` is 1 only during bits that the host transmits. It is 0 for every bit clocked in from the target and 0 at idle.
- R4: A receive (`reqKind` = 2'b01) runs 8 clock pulses and samples `linkDataIn` at the end of each clock-high phase, most significant bit first. The 8 bits form `doneData`.
- R5: An instruction (`reqKind[1]` = 1) with length L in `reqLen` (1 to 3) first transmits the header 0x54 | L. It then transmits L operand bytes, taken from `reqOperands[7:0]`, then `[15:8]`, then `[23:16]`.
- R6: After the last operand byte of an instruction, the block reads exactly one byte from the target with the data line released. That byte is reported on `doneData`.
- R7: Each clock-high phase and each clock-low phase lasts `HALF_CYCLES` system clocks. A request that moves N bytes keeps `busy` high for exactly N*16*`HALF_CYCLES` cycles.
- R8: `busy` rises on the cycle after acceptance and falls after the final clock-low phase. `doneValid` is a single-cycle pulse in the first idle cycle. For a send, `doneData` is 0x00.
- R9: While `busy` is high, `reqReady` is 0. A `reqValid` presented then, with any field values, has no effect on the link bits, on `doneData` or on the number of completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqKind | input | 2 | 00 send, 01 receive, 1x instruction |
| reqLen | input | 2 | Instruction operand count (1 to 3) |
| reqOperands | input | 24 | Send byte or instruction operands, first operand in bits 7:0 |
| busy | output | 1 | Transfer in progress |
| doneValid | output | 1 | One-cycle completion pulse |
| doneData | output | 8 | Byte received from the target |
| linkClk | output | 1 | Link clock, high at idle |
| linkDataOut | output | 1 | Data value driven toward the target |
| linkDataOe | output | 1 | Output enable for the data wire |
| linkDataIn | input | 1 | Data value read from the wire |

## Verification
The bench sweeps every send byte and every receive pattern, and runs every instruction length with several operand sets. If the bit order were reversed, or a shift were off by one, whole bytes would come out mirrored or rotated. Sampling on the wrong half of the clock would return each received byte shifted by one bit. If the enable were left on into the reply byte, the bench would see reply bits logged as host-driven. A wrong operand count or a missing reply read changes the number of bits and the busy length. A request poked in mid-transfer would show up as a second completion or a corrupted bit stream if it were accepted.

// File: rtl/dbg_link_pkg.sv
package dbg_link_pkg;
  localparam int BYTE_W  = 8;
  localparam int MAX_OPS = 3;
  localparam int OPS_W   = BYTE_W * MAX_OPS;
  localparam int QUEUE_W = BYTE_W * (MAX_OPS + 1);
  localparam int BIT_W   = $clog2(BYTE_W);
  localparam int CNT_W   = $clog2(MAX_OPS + 3);
  localparam logic [BYTE_W-1:0] HDR_BASE = 8'h54;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } link_state_t;

  typedef struct packed {
    logic capture;
    logic shiftOut;
    logic sampleIn;
  } dp_strobe_t;
endpackage

// File: rtl/dbg_link_ctrl.sv
module dbg_link_ctrl
  import dbg_link_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqKind,
  input  logic [1:0] reqLen,
  output logic       reqReady,
  output logic       busy,
  output logic       linkClk,
  output logic       linkDataOe,
  output logic       doneValid,
  output dp_strobe_t strobe
);
  localparam int DIV_W = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_CYCLES - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BYTE_W - 1);

  link_state_t      state;
  logic [DIV_W-1:0] divCnt;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] byteIdx;
  logic [CNT_W-1:0] txBytes;
  logic [CNT_W-1:0] totalBytes;
  logic             doneQ;

  logic accept, txNow, phaseEnd, lastBit, lastByte;

  always_comb begin
    accept   = reqValid && (state == ST_IDLE);
    txNow    = byteIdx < txBytes;
    phaseEnd = divCnt == DIV_LAST;
    lastBit  = bitCnt == BIT_LAST;
    lastByte = byteIdx == (totalBytes - CNT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      divCnt     <= '0;
      bitCnt     <= '0;
      byteIdx    <= '0;
      txBytes    <= '0;
      totalBytes <= '0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_HIGH;
            divCnt  <= '0;
            bitCnt  <= '0;
            byteIdx <= '0;
            if (reqKind[1]) begin
              txBytes    <= CNT_W'(reqLen) + CNT_W'(1);
              totalBytes <= CNT_W'(reqLen) + CNT_W'(2);
            end else begin
              txBytes    <= reqKind[0] ? CNT_W'(0) : CNT_W'(1);
              totalBytes <= CNT_W'(1);
            end
          end
        end
        ST_HIGH: begin
          if (phaseEnd) begin
            state  <= ST_LOW;
            divCnt <= '0;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_LOW: begin
          if (phaseEnd) begin
            divCnt <= '0;
            bitCnt <= bitCnt + BIT_W'(1);
            if (lastBit && lastByte) begin
              state <= ST_IDLE;
              doneQ <= 1'b1;
            end else begin
              state <= ST_HIGH;
              if (lastBit) byteIdx <= byteIdx + CNT_W'(1);
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.capture  = accept;
    strobe.shiftOut = (state == ST_LOW) && phaseEnd && txNow;
    strobe.sampleIn = (state == ST_HIGH) && phaseEnd && !txNow;
    reqReady        = state == ST_IDLE;
    busy            = state != ST_IDLE;
    linkClk         = state != ST_LOW;
    linkDataOe      = (state != ST_IDLE) && txNow;
    doneValid       = doneQ;
  end
endmodule

// File: rtl/dbg_link_dp.sv
module dbg_link_dp
  import dbg_link_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic [1:0]        reqKind,
  input  logic [1:0]        reqLen,
  input  logic [OPS_W-1:0]  reqOperands,
  input  logic              linkDataIn,
  output logic              linkDataOut,
  output logic [BYTE_W-1:0] rxByte
);
  logic [QUEUE_W-1:0] txQueue;
  logic [OPS_W-1:0]   opsOrdered;
  logic [BYTE_W-1:0]  header;

  // first operand ends up nearest the top of the queue
  always_comb begin
    opsOrdered = '0;
    for (int k = 0; k < MAX_OPS; k++) begin
      opsOrdered[OPS_W-1-k*BYTE_W -: BYTE_W] = reqOperands[k*BYTE_W +: BYTE_W];
    end
    header = HDR_BASE | BYTE_W'(reqLen);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txQueue <= '0;
      rxByte  <= '0;
    end else if (strobe.capture) begin
      rxByte <= '0;
      if (reqKind[1]) txQueue <= {header, opsOrdered};
      else            txQueue <= {reqOperands[BYTE_W-1:0], {(QUEUE_W-BYTE_W){1'b0}}};
    end else begin
      if (strobe.shiftOut) txQueue <= {txQueue[QUEUE_W-2:0], 1'b0};
      if (strobe.sampleIn) rxByte  <= {rxByte[BYTE_W-2:0], linkDataIn};
    end
  end

  assign linkDataOut = txQueue[QUEUE_W-1];
endmodule

// File: rtl/dbg_link_shifter.sv
module dbg_link_shifter
  import dbg_link_pkg::*;
#(
  parameter int HALF_CYCLES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  output logic        reqReady,
  input  logic [1:0]  reqKind,
  input  logic [1:0]  reqLen,
  input  logic [23:0] reqOperands,
  output logic        busy,
  output logic        doneValid,
  output logic [7:0]  doneData,
  output logic        linkClk,
  output logic        linkDataOut,
  output logic        linkDataOe,
  input  logic        linkDataIn
);
  dp_strobe_t strobe;

  dbg_link_ctrl #(.HALF_CYCLES(HALF_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqLen(reqLen), .reqReady(reqReady), .busy(busy), .linkClk(linkClk),
    .linkDataOe(linkDataOe), .doneValid(doneValid), .strobe(strobe)
  );

  dbg_link_dp dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqKind(reqKind),
    .reqLen(reqLen), .reqOperands(reqOperands), .linkDataIn(linkDataIn),
    .linkDataOut(linkDataOut), .rxByte(doneData)
  );
endmodule

// File: rtl/dbg_link_shifter_chk.sv
module dbg_link_shifter_chk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic busy,
  input logic doneValid,
  input logic linkClk,
  input logic linkDataOut,
  input logic linkDataOe
);
  // R3
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkDataOe |-> busy);
  // R1
  idle_clk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (linkClk && !linkDataOe));
  // R2
  data_hold_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!linkClk && linkDataOe) |-> $stable(linkDataOut));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> doneValid);
  // R9
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !reqReady);
endmodule

bind dbg_link_shifter dbg_link_shifter_chk chk_i (.*);

// File: tb/dbg_link_shifter_tb.sv
module dbg_link_shifter_tb_top;
  localparam int HALF = 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN, reqValid, reqReady, busy, doneValid;
  logic [1:0]  reqKind, reqLen;
  logic [23:0] reqOperands;
  logic [7:0]  doneData;
  logic        linkClk, linkDataOut, linkDataOe, linkDataIn;

  dbg_link_shifter #(.HALF_CYCLES(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqLen(reqLen), .reqOperands(reqOperands),
    .busy(busy), .doneValid(doneValid), .doneData(doneData),
    .linkClk(linkClk), .linkDataOut(linkDataOut), .linkDataOe(linkDataOe),
    .linkDataIn(linkDataIn)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [31:0] txLog;
  int txBits, rxFalls, busyCycles, doneCount;
  logic [7:0] rxPat;

  // target model: presents reply bits MSB first, next bit after each fall
  assign linkDataIn = (rxFalls < 8) ? rxPat[3'(7 - rxFalls)] : 1'b0;

  always @(negedge linkClk) begin
    if (linkDataOe) begin
      txLog  = {txLog[30:0], linkDataOut};
      txBits = txBits + 1;
    end else begin
      rxFalls = rxFalls + 1;
    end
  end

  always @(negedge clk) begin
    if (busy) busyCycles = busyCycles + 1;
    if (doneValid) doneCount = doneCount + 1;
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input logic ok, input string tag, input longint act, input longint exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic runReq(input logic [1:0] kind, input logic [1:0] len,
                        input logic [23:0] ops, input logic [7:0] pat,
                        input bit poke);
    int nTx, nBytes;
    logic [63:0] full, expTx, mask;
    logic [7:0] expRx;
    txLog = '0; txBits = 0; rxFalls = 0; busyCycles = 0; doneCount = 0;
    rxPat = pat;
    if (kind[1]) begin
      nTx = 1 + int'(len); nBytes = nTx + 1;
      full = {32'd0, 8'h54 | {6'd0, len}, ops[7:0], ops[15:8], ops[23:16]};
      expTx = full >> (8 * (3 - int'(len)));
      expRx = pat;
    end else if (kind[0]) begin
      nTx = 0; nBytes = 1; expTx = '0; expRx = pat;
    end else begin
      nTx = 1; nBytes = 1; expTx = {56'd0, ops[7:0]}; expRx = 8'h00;
    end
    mask = (64'd1 << (8 * nTx)) - 64'd1;
    @(negedge clk);
    reqValid = 1'b1; reqKind = kind; reqLen = len; reqOperands = ops;
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin
      repeat (5) @(negedge clk);
      reqValid = 1'b1; reqKind = 2'b00; reqLen = 2'd3; reqOperands = 24'hA5C3FF;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        check(reqReady == 1'b0, "R9 ready low while busy", reqReady, 0);
      end
      reqValid = 1'b0;
    end
    while (doneValid !== 1'b1) @(negedge clk);
    // R2 R5: transmitted bit stream
    check(txBits == 8 * nTx, "R2/R5 tx bit count", txBits, 8 * nTx);
    check(({32'd0, txLog} & mask) == expTx, "R2/R5 tx bits", {32'd0, txLog} & mask, expTx);
    // R3 R4 R6: released data line for reply bits only
    check(rxFalls == (nBytes - nTx) * 8, "R3/R6 released bits", rxFalls, (nBytes - nTx) * 8);
    check(doneData == expRx, "R4/R6/R8 doneData", doneData, expRx);
    // R7: phase length
    check(busyCycles == nBytes * 16 * HALF, "R7 busy length", busyCycles, nBytes * 16 * HALF);
    @(negedge clk);
    @(negedge clk);
    // R8 R9: single completion, back to idle
    check(doneCount == 1, "R8/R9 completion count", doneCount, 1);
    check(!busy && reqReady && linkClk && !linkDataOe, "R1 idle after done",
          {busy, reqReady, linkClk, linkDataOe}, 4'b0110);
  endtask

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqKind = '0; reqLen = '0; reqOperands = '0;
    rxPat = '0; txLog = '0; txBits = 0; rxFalls = 0; busyCycles = 0; doneCount = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(linkClk == 1'b1, "R1 clk high", linkClk, 1);
    check(linkDataOe == 1'b0, "R1 oe low", linkDataOe, 0);
    check(busy == 1'b0 && reqReady == 1'b1, "R1 ready", {busy, reqReady}, 2'b01);
    check(doneValid == 1'b0, "R1 no done", doneValid, 0);

    for (int v = 0; v < 256; v++) runReq(2'b00, 2'd0, {16'hBEEF, 8'(v)}, 8'(255 - v), 1'b0);
    for (int v = 0; v < 256; v++) runReq(2'b01, 2'd0, 24'h123456, 8'(v), 1'b0);
    for (int len = 1; len <= 3; len++) begin
      for (int k = 0; k < 8; k++) begin
        runReq((k % 2 == 0) ? 2'b10 : 2'b11, 2'(len),
               {8'(k * 13 + 200), 8'(k * 91 + 3), 8'(k * 37 + len)},
               8'(k * 29 + len * 71), 1'b0);
      end
    end
    runReq(2'b10, 2'd3, 24'h0F1E2D, 8'h96, 1'b1);
    runReq(2'b01, 2'd0, 24'h000000, 8'h3C, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule